// File: doc/BRIEF.md
# I2C Line Conflict Monitor

This block sits beside an open-drain I2C controller and compares, on every clock, the level the controller means to put on SCL and SDA with the level it reads back from each wire. A difference that lasts only a few cycles is normal, because the wire needs time to rise and the read-back path adds delay. Such short differences are ignored. A difference that survives a whole persistence window raises that line's alarm.

The two alarms lead to different actions. An SCL alarm seen while SCL reads low means a slave is holding the clock or another master is clocking the bus. The block answers with a one-cycle stretch-low request, so the local clock generator drops into its low phase. In the same cycle it pulses a clear that wipes both persistence histories, so the next conflict must again last a full window. The SDA alarm becomes an arbitration-loss flag, but only while SCL is high. This keeps an early acknowledge during the low phase from being taken as a lost arbitration.

Top module: `i2c_conflict_monitor`

## Requirements
- R1: A line counts as mismatched in a cycle only while its driver enable is 1 and its intended level differs from the level read on the wire. A mismatch with the driver enable at 0 is ignored.
- R2: A line's alarm goes to 1 after the clock edge that completes WIN consecutive mismatched samples (WIN defaults to 4). Any matched sample inside the window keeps the alarm at 0 until a new full run of WIN is complete.
- R3: If the SCL alarm is 1 and SCL reads 0 at a clock edge (and clear is 0), then stretch_low and clear are both 1 in the following cycle. An SCL alarm while SCL reads 1 produces neither.
- R4: clear is a single-cycle pulse and is 0 in the cycle after it was 1.
- R5: The edge at which clear is 1 empties both persistence histories. Both alarms are 0 in the next cycle, and a new alarm needs WIN more mismatched samples.
- R6: arb_lost equals the SDA alarm while SCL reads 1, and is 0 whenever SCL reads 0.
- R7: While a line's driver enable is 0, that line's alarm output is 0 in the same cycle.
- R8: While rst_n is 0, all outputs are 0 and both histories are empty.
- R9: stretch_low is high in exactly the cycles in which clear is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_drive_en | input | 1 | Local SCL driver is active |
| scl_intent | input | 1 | Level the controller wants on SCL |
| scl_in | input | 1 | Level read back from the SCL wire |
| sda_drive_en | input | 1 | Local SDA driver is active |
| sda_intent | input | 1 | Level the controller wants on SDA |
| sda_in | input | 1 | Level read back from the SDA wire |
| scl_alarm | output | 1 | Persistent SCL conflict |
| sda_alarm | output | 1 | Persistent SDA conflict |
| stretch_low | output | 1 | One-cycle request to force the clock generator low |
| clear | output | 1 | One-cycle pulse that resets both histories |
| arb_lost | output | 1 | SDA conflict while SCL is high |

## Verification
The bench places a single matched sample inside a mismatch run. A design that only counted mismatches in total, or that reset too late, would raise the alarm early. It keeps an SCL conflict going after the clear pulse and requires the alarm to come back exactly WIN edges later. A design that did not empty the history, or that pulsed clear every cycle, would fire at once or too often. It also drives an SCL conflict with the wire high, which must not stretch. It lets the SDA alarm stay up while SCL falls, which must drop arb_lost at once. It disables the SDA driver during a live conflict, which must silence the alarm in the same cycle. Finally it checks that one clear also wipes a parallel SDA history.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  localparam int NLINES   = 2;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/lcm_persist.sv
module lcm_persist #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_en,
  input  logic intent,
  input  logic observed,
  input  logic wipe,
  output logic alarm
);
  logic [WIN-1:0] hist_q;
  logic [WIN-1:0] hist_d;
  logic [WIN:0]   shifted;
  logic           miss;

  // next-state: shift the masked mismatch in, or empty on wipe
  always_comb begin
    miss    = drive_en & (intent ^ observed);
    shifted = {hist_q, miss};
    hist_d  = wipe ? '0 : shifted[WIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign alarm = drive_en & (&hist_q);
endmodule

// File: rtl/lcm_sync.sv
module lcm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_alarm,
  input  logic scl_obs,
  output logic pulse
);
  logic pulse_q;
  logic pulse_d;

  always_comb pulse_d = scl_alarm & ~scl_obs & ~pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/i2c_conflict_monitor.sv
module i2c_conflict_monitor
  import lcm_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_drive_en,
  input  logic scl_intent,
  input  logic scl_in,
  input  logic sda_drive_en,
  input  logic sda_intent,
  input  logic sda_in,
  output logic scl_alarm,
  output logic sda_alarm,
  output logic stretch_low,
  output logic clear,
  output logic arb_lost
);
  line_vec_t en_v, int_v, obs_v, alarm_v;
  logic      sync_pulse;

  assign en_v[LINE_SCL]  = scl_drive_en;
  assign en_v[LINE_SDA]  = sda_drive_en;
  assign int_v[LINE_SCL] = scl_intent;
  assign int_v[LINE_SDA] = sda_intent;
  assign obs_v[LINE_SCL] = scl_in;
  assign obs_v[LINE_SDA] = sda_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    lcm_persist #(.WIN(WIN)) u_persist (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_en (en_v[g]),
      .intent   (int_v[g]),
      .observed (obs_v[g]),
      .wipe     (sync_pulse),
      .alarm    (alarm_v[g])
    );
  end

  lcm_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_alarm (alarm_v[LINE_SCL]),
    .scl_obs   (scl_in),
    .pulse     (sync_pulse)
  );

  assign scl_alarm   = alarm_v[LINE_SCL];
  assign sda_alarm   = alarm_v[LINE_SDA];
  assign stretch_low = sync_pulse;
  assign clear       = sync_pulse;
  assign arb_lost    = alarm_v[LINE_SDA] & scl_in;
endmodule

// File: rtl/lcm_checker.sv
module lcm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_drive_en,
  input logic sda_intent,
  input logic sda_in,
  input logic scl_alarm,
  input logic sda_alarm,
  input logic stretch_low,
  input logic clear,
  input logic arb_lost
);
  assert_sync_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_alarm && !scl_in && !clear) |=> (clear && stretch_low));

  assert_clear_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !clear);

  assert_clear_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!scl_alarm && !sda_alarm));

  assert_arb_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_in |-> !arb_lost);

  assert_sda_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_drive_en |-> !sda_alarm);

  assert_alarm_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_alarm) |-> $past(sda_drive_en && (sda_intent != sda_in)));
endmodule

bind i2c_conflict_monitor lcm_checker u_lcm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_in       (scl_in),
  .sda_drive_en (sda_drive_en),
  .sda_intent   (sda_intent),
  .sda_in       (sda_in),
  .scl_alarm    (scl_alarm),
  .sda_alarm    (sda_alarm),
  .stretch_low  (stretch_low),
  .clear        (clear),
  .arb_lost     (arb_lost)
);

// File: tb/sim_i2c_conflict_monitor.sv
`timescale 1ns/1ps
module sim_i2c_conflict_monitor;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_drive_en, scl_intent, scl_in, sda_drive_en, sda_intent, sda_in;
  logic scl_alarm, sda_alarm, stretch_low, clear, arb_lost;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  i2c_conflict_monitor #(.WIN(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .scl_drive_en(scl_drive_en), .scl_intent(scl_intent), .scl_in(scl_in),
    .sda_drive_en(sda_drive_en), .sda_intent(sda_intent), .sda_in(sda_in),
    .scl_alarm(scl_alarm), .sda_alarm(sda_alarm), .stretch_low(stretch_low),
    .clear(clear), .arb_lost(arb_lost)
  );

  // inputs {scl_en, scl_int, scl_ln, sda_en, sda_int, sda_ln},
  // expected {scl_alarm, sda_alarm, stretch_low, clear, arb_lost}
  localparam int NV = 22;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {6'b111101, 5'b00000}, {6'b111101, 5'b00000}, {6'b111111, 5'b00000},
    {6'b111101, 5'b00000}, {6'b111101, 5'b00000}, {6'b111101, 5'b00000},
    {6'b111101, 5'b01001}, {6'b100101, 5'b01000}, {6'b111010, 5'b00000},
    {6'b111111, 5'b00000}, {6'b110111, 5'b00000}, {6'b110111, 5'b00000},
    {6'b110111, 5'b00000}, {6'b110111, 5'b10000}, {6'b110111, 5'b10110},
    {6'b110111, 5'b00000}, {6'b110111, 5'b00000}, {6'b110111, 5'b00000},
    {6'b110111, 5'b00000}, {6'b110111, 5'b10000}, {6'b101111, 5'b10000},
    {6'b101111, 5'b10000}
  };

  function automatic string vec_tag(int i);
    if (i <= 6)  return "R2 persistence/R1 mismatch";
    if (i == 7)  return "R6 arb qualified by SCL";
    if (i == 8)  return "R7 SDA driver disabled";
    if (i <= 13) return "R1 SCL mismatch window";
    if (i == 14) return "R3 stretch and clear, R9 aligned";
    if (i == 15) return "R4 single pulse, R5 wipe";
    if (i <= 19) return "R5 fresh window";
    return "R3 no stretch with SCL high";
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%05b expected=%05b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {scl_alarm, sda_alarm, stretch_low, clear, arb_lost};
  endfunction

  task automatic drive(logic [5:0] v);
    {scl_drive_en, scl_intent, scl_in, sda_drive_en, sda_intent, sda_in} = v;
  endtask

  task automatic step(logic [5:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(6'b111101);
    repeat (3) @(negedge clk);
    check("R8 reset state", outs(), 5'b00000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10:5]);
      check(vec_tag(i), outs(), VEC[i][4:0]);
    end

    // R5: one clear wipes a parallel SDA history too
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(6'b110101);
    check("R2 both alarms, R6 arb low with SCL low", outs(), 5'b11000);
    step(6'b110101);
    check("R3 stretch with SCL low", outs(), 5'b11110);
    step(6'b110101);
    check("R5 both histories wiped", outs(), 5'b00000);
    for (int i = 0; i < 3; i++) step(6'b111101);
    check("R5 SDA needs full window again", outs(), 5'b00000);
    step(6'b111101);
    check("R6 arb with SCL high", outs(), 5'b01001);
    drive(6'b111001);
    #1;
    check("R7 SDA alarm off same cycle", outs(), 5'b00000);
    drive(6'b011101);
    #1;
    check("R1 SDA alarm back, SCL driver off", outs(), 5'b01001);

    // R8: asynchronous reset during an alarm
    #3 rst_n = 1'b0;
    #2;
    check("R8 reset mid alarm", outs(), 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(6'b111101);
    check("R8 history empty after reset", outs(), 5'b00000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule